// File: doc/BRIEF.md
# Serial Control-Register Slave with Block Transfers

This block is a slave on a two-wire serial bus (I2C-style signalling). It holds a small bank of 8-bit control registers that a bus master can write and read back, and it presents every register in parallel to the surrounding logic. The SCL and SDA lines are oversampled with the system clock after a two-flop synchronizer. The slave never drives SDA high. It only pulls the line low, through an open-drain enable output.

Writes always use a block format. After the write address byte, the master sends two filler bytes. The slave acknowledges both and discards their contents. Every byte after them lands in register 0, then register 1, and so on until the stop condition. Reads have no command phase. Directly after the read address is acknowledged, the slave returns register 0, then register 1, and so on for as long as the master keeps acknowledging. Two identification registers at the top of the bank are fixed and cannot be written.

Top module: `ctlreg_i2c_slave`

## Requirements
- R1: The 7-bit device address is 1101001. The slave acknowledges address byte 0xD2 (write, LSB 0) and address byte 0xD3 (read, LSB 1) by pulling SDA low during the ninth clock.
- R2: Any other address byte is not acknowledged. The slave then ignores all further bytes, leaves SDA released and changes no register until the next start condition.
- R3: In a write, the two bytes that follow the address are acknowledged and their values are discarded. No register takes their value.
- R4: Write data bytes are stored in register 0, 1, 2 and onward in order, each acknowledged, until a stop condition. Bits arrive MSB first.
- R5: In a read, the slave sends register 0 directly after the address acknowledge, then the following registers in order, MSB first.
- R6: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Either one releases SDA and aborts any byte in progress. A stop returns the slave to idle, and a start (including a repeated start) begins a new address phase.
- R7: Register 14 reads 0x62 and register 15 reads 0xA2. Writes to them are acknowledged and ignored.
- R8: With the default of 16 registers, data bytes written beyond register 15 are acknowledged and discarded.
- R9: Read bytes beyond the last register return 0xFF, which means SDA stays released.
- R10: When the master does not acknowledge a read byte, the slave stops driving SDA until the next start or stop.
- R11: After reset, registers 0 to 13 hold 0x00 and SDA is released.
- R12: The SDA pull output changes only in the cycle after a synchronized SCL falling edge, start or stop. A register takes a written byte two cycles after the SCL falling edge that ends that byte's eighth bit, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | NUM_REGS*8 | All registers in parallel, register k at bits [8k+7:8k] |

## Verification
On every cycle, the assertions check the bus-side timing rules. SDA moves only after an SCL fall, a start or a stop. Both start and stop release the line. Register contents change only two cycles after an SCL fall. Only the bench's scenarios can show the data-path effects: which address bytes get an acknowledge, that the two filler bytes are discarded, the order in which write data fills the bank, the order and content of read-back, the fixed identification bytes, the handling of transfers that run past the end in either direction, and the silence of the slave after a master NACK or a foreign address.

// File: rtl/ctlreg_pkg.sv
// Shared types for the serial control-register slave.
// Assumes: nothing outside this package.
package ctlreg_pkg;

    // Protocol engine states
    typedef enum logic [2:0] {
        ENG_IDLE,   // waiting for a start condition
        ENG_RX,     // shifting in a byte from the master
        ENG_ACK,    // holding SDA low for the acknowledge clock
        ENG_TX,     // shifting out a byte to the master
        ENG_MACK    // sampling the master's acknowledge
    } eng_state_t;

    // Which byte of a transaction is being received
    typedef enum logic [1:0] {
        PH_ADDR,    // device address plus direction
        PH_CMD,     // first filler byte (ignored)
        PH_CNT,     // second filler byte (ignored)
        PH_DATA     // register data
    } rx_phase_t;

endpackage

// File: rtl/ctlreg_line_sync.sv
// Synchronizes SCL and SDA into the system clock domain and flags SCL
// edges and the start and stop conditions.
// Assumes: the bus is idle-high, and STAGES is at least 2.
module ctlreg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] scl_pipe;
    logic [TOP:0] sda_pipe;
    logic         scl_d;
    logic         sda_d;
    logic         scl_q;

    // Synchronizer chains plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
            sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
            scl_d    <= scl_pipe[TOP];
            sda_d    <= sda_pipe[TOP];
        end
    end

    // Edge and bus-condition decode
    always_comb begin
        scl_q    = scl_pipe[TOP];
        sda_q    = sda_pipe[TOP];
        scl_rise = scl_q & ~scl_d;
        scl_fall = ~scl_q & scl_d;
        start_ev = scl_q & scl_d & sda_d & ~sda_q;
        stop_ev  = scl_q & scl_d & ~sda_d & sda_q;
    end

endmodule

// File: rtl/ctlreg_engine.sv
// Byte-level protocol engine: address match, two filler bytes, sequential
// writes from register 0, and sequential reads from register 0.
// Assumes: single-cycle edge and condition strobes from the synchronizer,
// and rd_byte reflecting the register at ptr in the same cycle.
module ctlreg_engine
    import ctlreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101001,
    parameter int         NUM_REGS = 16,
    parameter int         PTR_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_q,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic [7:0]       rd_byte,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_byte,
    output logic             sda_pull
);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);
    localparam logic [3:0]       BYTE_BITS = 4'd8;

    eng_state_t state;
    rx_phase_t  phase;
    logic       is_read;
    logic       mack_ok;
    logic [3:0] bitcnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;

    // Main protocol sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ENG_IDLE;
            phase    <= PH_ADDR;
            is_read  <= 1'b0;
            mack_ok  <= 1'b0;
            bitcnt   <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            ptr      <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_byte  <= '0;
            sda_pull <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev) begin
                state    <= ENG_RX;
                phase    <= PH_ADDR;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else if (stop_ev) begin
                state    <= ENG_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ENG_RX: begin
                        if (scl_rise && bitcnt != BYTE_BITS) begin
                            rx_sh  <= {rx_sh[6:0], sda_q};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == BYTE_BITS) begin
                            case (phase)
                                PH_ADDR: begin
                                    if (rx_sh[7:1] == DEV_ADDR) begin
                                        sda_pull <= 1'b1;
                                        state    <= ENG_ACK;
                                        is_read  <= rx_sh[0];
                                        ptr      <= '0;
                                        phase    <= PH_CMD;
                                    end else begin
                                        state <= ENG_IDLE;
                                    end
                                end
                                PH_CMD: begin
                                    sda_pull <= 1'b1;
                                    state    <= ENG_ACK;
                                    phase    <= PH_CNT;
                                end
                                PH_CNT: begin
                                    sda_pull <= 1'b1;
                                    state    <= ENG_ACK;
                                    phase    <= PH_DATA;
                                end
                                default: begin
                                    sda_pull <= 1'b1;
                                    state    <= ENG_ACK;
                                    wr_en    <= 1'b1;
                                    wr_addr  <= ptr;
                                    wr_byte  <= rx_sh;
                                    if (ptr != PTR_END) ptr <= ptr + 1'b1;
                                end
                            endcase
                        end
                    end
                    ENG_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (is_read) begin
                                tx_sh    <= rd_byte;
                                sda_pull <= ~rd_byte[7];
                                if (ptr != PTR_END) ptr <= ptr + 1'b1;
                                state    <= ENG_TX;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ENG_RX;
                            end
                        end
                    end
                    ENG_TX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == BYTE_BITS) begin
                                sda_pull <= 1'b0;
                                state    <= ENG_MACK;
                            end else begin
                                tx_sh    <= {tx_sh[6:0], 1'b0};
                                sda_pull <= ~tx_sh[6];
                            end
                        end
                    end
                    ENG_MACK: begin
                        if (scl_rise) begin
                            mack_ok <= ~sda_q;
                        end else if (scl_fall) begin
                            bitcnt <= '0;
                            if (mack_ok) begin
                                tx_sh    <= rd_byte;
                                sda_pull <= ~rd_byte[7];
                                if (ptr != PTR_END) ptr <= ptr + 1'b1;
                                state    <= ENG_TX;
                            end else begin
                                state <= ENG_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/ctlreg_bank.sv
// Register bank: writable 8-bit registers plus two fixed identification
// registers that ignore writes.
// Assumes: the write strobe is one cycle long and addresses at or past
// NUM_REGS select nothing.
module ctlreg_bank #(
    parameter int         NUM_REGS = 16,
    parameter int         PTR_W    = 5,
    parameter int         ID0_IDX  = 14,
    parameter logic [7:0] ID0_VAL  = 8'h62,
    parameter int         ID1_IDX  = 15,
    parameter logic [7:0] ID1_VAL  = 8'hA2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_addr,
    input  logic [7:0]            wr_byte,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == ID0_IDX) begin : g_id0
            assign regs_flat[i*8 +: 8] = ID0_VAL;
        end else if (i == ID1_IDX) begin : g_id1
            assign regs_flat[i*8 +: 8] = ID1_VAL;
        end else begin : g_rw
            logic [7:0] q;
            // Storage for one writable register
            always_ff @(posedge clk) begin
                if (!rst_n)                                q <= 8'h00;
                else if (wr_en && wr_addr == PTR_W'(i))    q <= wr_byte;
            end
            assign regs_flat[i*8 +: 8] = q;
        end
    end

endmodule

// File: rtl/ctlreg_i2c_slave.sv
// Top of the serial control-register slave: synchronizer, protocol engine,
// register bank, and the read-side register select.
// Assumes: an external pull-up on SDA; sda_pull_o drives an open-drain pad.
module ctlreg_i2c_slave #(
    parameter logic [6:0] DEV_ADDR = 7'b1101001,
    parameter int         NUM_REGS = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam int PTR_W = $clog2(NUM_REGS + 1);

    logic             sda_q;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_ev;
    logic             stop_ev;
    logic [PTR_W-1:0] ptr;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [7:0]       wr_byte;
    logic [7:0]       rd_byte;

    ctlreg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_q    (sda_q),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    ctlreg_engine #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS),
        .PTR_W    (PTR_W)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_q    (sda_q),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rd_byte  (rd_byte),
        .ptr      (ptr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_byte  (wr_byte),
        .sda_pull (sda_pull_o)
    );

    ctlreg_bank #(
        .NUM_REGS (NUM_REGS),
        .PTR_W    (PTR_W),
        .ID0_IDX  (NUM_REGS - 2),
        .ID0_VAL  (8'h62),
        .ID1_IDX  (NUM_REGS - 1),
        .ID1_VAL  (8'hA2)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_byte   (wr_byte),
        .regs_flat (regs_o)
    );

    // Read-side select; past the last register the line stays released
    always_comb begin
        rd_byte = 8'hFF;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (ptr == PTR_W'(k)) rd_byte = regs_o[k*8 +: 8];
        end
    end

endmodule

// File: rtl/ctlreg_i2c_slave_chk.sv
// Timing checker for the serial control-register slave, bound to the top.
// Assumes: it sees the synchronizer strobes through the bind connection.
module ctlreg_i2c_slave_chk #(
    parameter int NUM_REGS = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sda_pull,
    input logic [NUM_REGS*8-1:0] regs_flat,
    input logic                  scl_fall,
    input logic                  start_ev,
    input logic                  stop_ev
);
    // R6
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_pull);

    // R6
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_pull);

    // R12
    sda_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> $past(scl_fall || start_ev || stop_ev));

    // R12
    reg_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_flat) |-> $past(scl_fall, 2));

endmodule

bind ctlreg_i2c_slave ctlreg_i2c_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_pull  (sda_pull_o),
    .regs_flat (regs_o),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev)
);

// File: tb/sim_ctlreg_i2c_slave.sv
// Bench for the serial control-register slave: a bus master built from
// tasks, a table of write/read-back vectors, then directed corner cases.
module sim_ctlreg_i2c_slave;
    localparam int NREG = 16;
    localparam int Q    = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scl = 1'b1;
    logic              sda_m = 1'b1;
    logic              sda_line;
    logic              sda_pull;
    logic [NREG*8-1:0] regs;

    int         errors = 0;
    int         checks = 0;
    logic [7:0] exp_r [NREG];
    logic [7:0] wbuf  [24];
    logic [7:0] snap_r0;
    logic       ack;
    logic [7:0] rb;

    // {filler1, filler2, d0, d1, d2}
    localparam logic [39:0] VEC [4] = '{
        40'hFF_00_A5_3C_81,
        40'h00_FF_01_02_04,
        40'h5A_5A_FE_7F_00,
        40'h12_34_C3_96_E1
    };

    assign sda_line = sda_m & ~sda_pull;

    always #10 clk = ~clk;

    ctlreg_i2c_slave u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .regs_o     (regs)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    // Sends a byte MSB first; ack=1 when the slave pulled SDA low
    task automatic send_byte(input logic [7:0] b, output logic a);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl = 1'b1; wq();
            if (i == 0) snap_r0 = regs[7:0];
            scl = 1'b0;
        end
        sda_m = 1'b1; wq(); scl = 1'b1; wq();
        a = ~sda_line;
        scl = 1'b0; wq();
    endtask

    // Receives a byte; m_ack=1 acknowledges it
    task automatic recv_byte(input logic m_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wq(); scl = 1'b1; wq();
            b = {b[6:0], sda_line};
            scl = 1'b0;
        end
        sda_m = ~m_ack; wq(); scl = 1'b1; wq(); scl = 1'b0; sda_m = 1'b1; wq();
    endtask

    // Write transaction: address, two fillers, n data bytes, optional stop
    task automatic write_txn(input logic [7:0] f1, input logic [7:0] f2,
                             input int n, input logic do_stop, input string req);
        logic a;
        bus_start();
        send_byte(8'hD2, a); chk({7'd0, a}, 8'd1, "R1 write address ack");
        send_byte(f1, a);    chk({7'd0, a}, 8'd1, "R3 filler 1 ack");
        send_byte(f2, a);    chk({7'd0, a}, 8'd1, "R3 filler 2 ack");
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a); chk({7'd0, a}, 8'd1, req);
            if (i < NREG && i != NREG - 2 && i != NREG - 1) exp_r[i] = wbuf[i];
        end
        if (do_stop) bus_stop();
    endtask

    task automatic check_bank(input string req);
        for (int k = 0; k < NREG; k++) chk(regs[k*8 +: 8], exp_r[k], req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic a;
        for (int k = 0; k < NREG; k++) exp_r[k] = 8'h00;
        exp_r[NREG-2] = 8'h62;
        exp_r[NREG-1] = 8'hA2;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11 and R7: reset contents and released line
        check_bank("R11 reset bank / R7 id bytes");
        chk({7'd0, sda_pull}, 8'd0, "R11 SDA released after reset");

        // Vector table: write three bytes, then read them back
        for (int v = 0; v < 4; v++) begin
            wbuf[0] = VEC[v][23:16]; wbuf[1] = VEC[v][15:8]; wbuf[2] = VEC[v][7:0];
            write_txn(VEC[v][39:32], VEC[v][31:24], 3, 1'b1, "R4 data ack");
            for (int k = 0; k < 3; k++) chk(regs[k*8 +: 8], exp_r[k], "R4 R3 stored data, fillers dropped");
            chk(regs[31:24], exp_r[3], "R3 register 3 untouched");
            bus_start();
            send_byte(8'hD3, a); chk({7'd0, a}, 8'd1, "R1 read address ack");
            for (int k = 0; k < 3; k++) begin
                recv_byte(k != 2, rb); chk(rb, exp_r[k], "R5 read-back order");
            end
            bus_stop();
        end

        // R2: foreign address, then bytes that must be ignored
        bus_start();
        send_byte(8'hA4, a); chk({7'd0, a}, 8'd0, "R2 foreign address not acked");
        send_byte(8'h00, a); chk({7'd0, a}, 8'd0, "R2 following byte not acked");
        send_byte(8'h77, a); chk({7'd0, a}, 8'd0, "R2 data ignored");
        bus_stop();
        check_bank("R2 bank unchanged");

        // R12: register 0 unchanged at the 8th SCL high, updated afterwards
        wbuf[0] = 8'h3C;
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(wbuf[0], a);
        chk(snap_r0, exp_r[0], "R12 no update before SCL fall");
        exp_r[0] = wbuf[0];
        chk(regs[7:0], 8'h3C, "R12 updated after byte end");
        bus_stop();

        // R7, R8: fill all registers and two more
        for (int i = 0; i < NREG + 2; i++) wbuf[i] = 8'(8'h10 + i * 8'h05);
        write_txn(8'h00, 8'h00, NREG + 2, 1'b1, "R8 ack through and past the end");
        check_bank("R7 R8 bank after overlong write");

        // R9: read past the end
        bus_start();
        send_byte(8'hD3, a);
        for (int k = 0; k < NREG + 1; k++) begin
            recv_byte(k != NREG, rb);
            chk(rb, (k < NREG) ? exp_r[k] : 8'hFF, (k < NREG) ? "R5 full read" : "R9 past end reads FF");
        end
        bus_stop();

        // R10: NACK on the first byte, then the slave must stay silent
        wbuf[0] = 8'h3C;
        write_txn(8'h00, 8'h00, 1, 1'b1, "R4 data ack");
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(1'b0, rb); chk(rb, 8'h3C, "R10 first byte before NACK");
        recv_byte(1'b1, rb); chk(rb, 8'hFF, "R10 line released after NACK");
        bus_stop();

        // R6: repeated start from a write into a read
        wbuf[0] = 8'h55;
        write_txn(8'h00, 8'h00, 1, 1'b0, "R4 data ack");
        bus_start();
        send_byte(8'hD3, a); chk({7'd0, a}, 8'd1, "R6 repeated start address ack");
        recv_byte(1'b0, rb); chk(rb, 8'h55, "R6 read after repeated start");
        bus_stop();

        // R6: after a stop, clocked bytes are not taken
        send_byte(8'h99, a); chk({7'd0, a}, 8'd0, "R6 idle after stop, no ack");
        check_bank("R6 bank unchanged after stop");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule